// File: doc/BRIEF.md
# Sliding-Surface Switching Function Unit

This block is the front end of a voltage-tracking control loop. Once per control sample it takes four signed words: the voltage reference, the reference's time derivative, the measured terminal voltage and the measured filter-capacitor current. From these it produces a signed switching-function word. That word is the weighted sum of two error terms. The derivative error is multiplied by a gain `k1` and the proportional error by a gain `k2`. The ratio `k1/k2` sets the time constant with which the tracking error decays. A typical choice is `k1 = 0.001 s` and `k2 = 2.5`, which gives 0.4 ms. At a 10 µs sample period this is forty samples.

The slope of the measured voltage is never found by differencing successive samples. It is the capacitor current multiplied by a programmable reciprocal of the capacitance, so each result depends only on the sample that produced it. The two gains and the reciprocal capacitance are unsigned fixed-point words. They are taken in on the same clock edge as the sample strobe and travel down the pipeline with that sample. All intermediate products and sums keep full precision. Only the final value is scaled down to the output format, rounded toward minus infinity and clamped. The result feeds a carrier-based modulator, which is outside this block.

Top module: `slide_surface_unit`

## Requirements
- R1: For a sample captured with inputs vr, dvr, vm, ic and configuration k1, k2, inv, the output word is y = floor(T / 2^SH), clamped to the output range.
  - T = k1·(dvr·2^CF − ic·inv)·2^(FA−CF−K1F) + k2·(vr−vm)·2^(FA−K2F).
  - FA = max(CF+K1F, K2F) and SH = FA − OF.
  - Defaults: CF=8, K1F=12, K2F=8, OF=0. k1 is Q4.12, k2 is Q8.8 and inv is Q8.8, all unsigned.
- R2: The measured slope comes only from ic·inv of the same sample. The same inputs give the same output whatever samples came before.
- R3: A result above 2^(OW−1)−1 is output as 2^(OW−1)−1, and one below −2^(OW−1) as −2^(OW−1). It never wraps. Default OW=16.
- R4: `vld_o` is high for exactly one cycle. This is the cycle after the fourth rising edge following the edge that samples `smp_i` high. A new sample is accepted on every cycle.
- R5: k1, k2 and inv are captured only on an edge where `smp_i` is high. Changing them at any other time has no effect on a sample already in flight.
- R6: While `rst_ni` is low, `sw_o` is 0 and `vld_o` is 0, and samples in flight are discarded.
- R7: `sw_o` holds its last value between `vld_o` pulses.
- R8: A sample with vr = vm, dvr = 0 and ic = 0 produces `sw_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | 1 | Sample strobe |
| vref_i | input | DW | Voltage reference, signed |
| dvref_i | input | DW | Reference derivative, signed |
| vmeas_i | input | DW | Measured terminal voltage, signed |
| icap_i | input | DW | Measured capacitor current, signed |
| k1_i | input | KW | Derivative gain, unsigned, K1F fraction bits |
| k2_i | input | KW | Proportional gain, unsigned, K2F fraction bits |
| invc_i | input | CW | Reciprocal capacitance, unsigned, CF fraction bits |
| sw_o | output | OW | Switching-function word, signed |
| vld_o | output | 1 | Result strobe |

## Verification
The assertions check four things on every cycle:
- the strobe always emerges four edges after its sample;
- reset clears both outputs;
- the output word never moves without a strobe;
- a zero-error sample yields zero.

The arithmetic itself is shown only by the bench's scenarios. These cover the weighted sum, rounding toward minus infinity on negative results, and clamping at both rails. They also cover the capture of gains with their own sample while the ports change mid-flight, and independence from earlier samples.

// File: rtl/sls_pkg.sv
package sls_pkg;
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sls_capture.sv
module sls_capture #(
  parameter int DW = 16,
  parameter int KW = 16,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [DW-1:0] dvref_i,
  input  logic signed [DW-1:0] vmeas_i,
  input  logic signed [DW-1:0] icap_i,
  input  logic        [KW-1:0] k1_i,
  input  logic        [KW-1:0] k2_i,
  input  logic        [CW-1:0] invc_i,
  output logic signed [DW-1:0] vref_o,
  output logic signed [DW-1:0] dvref_o,
  output logic signed [DW-1:0] vmeas_o,
  output logic signed [DW-1:0] icap_o,
  output logic        [KW-1:0] k1_o,
  output logic        [KW-1:0] k2_o,
  output logic        [CW-1:0] invc_o,
  output logic                 vld_o
);
  logic signed [DW-1:0] vref_d, dvref_d, vmeas_d, icap_d;
  logic        [KW-1:0] k1_d, k2_d;
  logic        [CW-1:0] invc_d;

  always_comb begin
    vref_d  = vref_o;
    dvref_d = dvref_o;
    vmeas_d = vmeas_o;
    icap_d  = icap_o;
    k1_d    = k1_o;
    k2_d    = k2_o;
    invc_d  = invc_o;
    if (en_i) begin
      vref_d  = vref_i;
      dvref_d = dvref_i;
      vmeas_d = vmeas_i;
      icap_d  = icap_i;
      k1_d    = k1_i;
      k2_d    = k2_i;
      invc_d  = invc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vref_o  <= '0;
      dvref_o <= '0;
      vmeas_o <= '0;
      icap_o  <= '0;
      k1_o    <= '0;
      k2_o    <= '0;
      invc_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      vref_o  <= vref_d;
      dvref_o <= dvref_d;
      vmeas_o <= vmeas_d;
      icap_o  <= icap_d;
      k1_o    <= k1_d;
      k2_o    <= k2_d;
      invc_o  <= invc_d;
      vld_o   <= en_i;
    end
  end
endmodule

// File: rtl/sls_error.sv
module sls_error #(
  parameter int DW = 16,
  parameter int KW = 16,
  parameter int CW = 16,
  parameter int CF = 8,
  localparam int PW  = DW + CW + 1,
  localparam int RW  = DW + CF,
  localparam int EDW = sls_pkg::imax(PW, RW) + 1,
  localparam int EPW = DW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [DW-1:0]  vref_i,
  input  logic signed [DW-1:0]  dvref_i,
  input  logic signed [DW-1:0]  vmeas_i,
  input  logic signed [DW-1:0]  icap_i,
  input  logic        [KW-1:0]  k1_i,
  input  logic        [KW-1:0]  k2_i,
  input  logic        [CW-1:0]  invc_i,
  output logic signed [EDW-1:0] ed_o,
  output logic signed [EPW-1:0] ep_o,
  output logic        [KW-1:0]  k1_o,
  output logic        [KW-1:0]  k2_o,
  output logic                  vld_o
);
  // first register set: proportional error, measured slope, aligned reference slope
  logic signed [EPW-1:0] ep_d, ep_q;
  logic signed [PW-1:0]  dvm_d, dvm_q;
  logic signed [RW-1:0]  dvr_d, dvr_q;
  logic        [KW-1:0]  k1_q, k2_q;
  logic                  v_q;
  // second register set: derivative error
  logic signed [EDW-1:0] ed_d;

  always_comb begin
    ep_d  = EPW'(vref_i) - EPW'(vmeas_i);
    dvm_d = PW'(icap_i) * PW'($signed({1'b0, invc_i}));
    dvr_d = RW'(dvref_i) <<< CF;
  end

  always_comb begin
    ed_d = EDW'(dvr_q) - EDW'(dvm_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_q  <= '0;
      dvm_q <= '0;
      dvr_q <= '0;
      k1_q  <= '0;
      k2_q  <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= vld_i;
      if (vld_i) begin
        ep_q  <= ep_d;
        dvm_q <= dvm_d;
        dvr_q <= dvr_d;
        k1_q  <= k1_i;
        k2_q  <= k2_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ed_o  <= '0;
      ep_o  <= '0;
      k1_o  <= '0;
      k2_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= v_q;
      if (v_q) begin
        ed_o <= ed_d;
        ep_o <= ep_q;
        k1_o <= k1_q;
        k2_o <= k2_q;
      end
    end
  end
endmodule

// File: rtl/sls_weight.sv
module sls_weight #(
  parameter int EDW = 34,
  parameter int EPW = 17,
  parameter int KW  = 16,
  localparam int T1W = EDW + KW + 1,
  localparam int T2W = EPW + KW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [EDW-1:0] ed_i,
  input  logic signed [EPW-1:0] ep_i,
  input  logic        [KW-1:0]  k1_i,
  input  logic        [KW-1:0]  k2_i,
  output logic signed [T1W-1:0] t1_o,
  output logic signed [T2W-1:0] t2_o,
  output logic                  vld_o
);
  logic signed [T1W-1:0] t1_d;
  logic signed [T2W-1:0] t2_d;

  always_comb begin
    t1_d = T1W'(ed_i) * T1W'($signed({1'b0, k1_i}));
    t2_d = T2W'(ep_i) * T2W'($signed({1'b0, k2_i}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_o  <= '0;
      t2_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        t1_o <= t1_d;
        t2_o <= t2_d;
      end
    end
  end
endmodule

// File: rtl/sls_combine.sv
module sls_combine #(
  parameter int T1W = 51,
  parameter int T2W = 34,
  parameter int A1  = 0,
  parameter int A2  = 12,
  parameter int SH  = 20,
  parameter int OW  = 16,
  localparam int SW = sls_pkg::imax(T1W + A1, T2W + A2) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [T1W-1:0] t1_i,
  input  logic signed [T2W-1:0] t2_i,
  output logic signed [OW-1:0]  sw_o,
  output logic                  vld_o
);
  localparam logic signed [SW-1:0] MAXV = $signed({{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}});
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0] sum, scl;
  logic signed [OW-1:0] sw_d;

  always_comb begin
    sum = (SW'(t1_i) <<< A1) + (SW'(t2_i) <<< A2);
    scl = sum >>> SH;
    if (scl > MAXV)      sw_d = MAXV[OW-1:0];
    else if (scl < MINV) sw_d = MINV[OW-1:0];
    else                 sw_d = scl[OW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) sw_o <= sw_d;
    end
  end
endmodule

// File: rtl/slide_surface_unit.sv
module slide_surface_unit #(
  parameter int DW  = 16,
  parameter int KW  = 16,
  parameter int CW  = 16,
  parameter int CF  = 8,
  parameter int K1F = 12,
  parameter int K2F = 8,
  parameter int OF  = 0,
  parameter int OW  = 16,
  parameter int RST_SYNC = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [DW-1:0] dvref_i,
  input  logic signed [DW-1:0] vmeas_i,
  input  logic signed [DW-1:0] icap_i,
  input  logic        [KW-1:0] k1_i,
  input  logic        [KW-1:0] k2_i,
  input  logic        [CW-1:0] invc_i,
  output logic signed [OW-1:0] sw_o,
  output logic                 vld_o
);
  localparam int PW  = DW + CW + 1;
  localparam int RW  = DW + CF;
  localparam int EDW = sls_pkg::imax(PW, RW) + 1;
  localparam int EPW = DW + 1;
  localparam int T1W = EDW + KW + 1;
  localparam int T2W = EPW + KW + 1;
  localparam int F1  = CF + K1F;
  localparam int FA  = sls_pkg::imax(F1, K2F);
  localparam int A1  = FA - F1;
  localparam int A2  = FA - K2F;
  localparam int SH  = FA - OF;

  // reset: asserted asynchronously, released after RST_SYNC clock edges
  logic [RST_SYNC-1:0] rs_q;
  logic                rst_n_int;
  genvar g;
  generate
    for (g = 0; g < RST_SYNC; g++) begin : g_rsync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rs_q[g] <= 1'b0;
        else if (g == 0) rs_q[g] <= 1'b1;
        else rs_q[g] <= rs_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign rst_n_int = rs_q[RST_SYNC-1];

  logic signed [DW-1:0]  c_vref, c_dvref, c_vmeas, c_icap;
  logic        [KW-1:0]  c_k1, c_k2, e_k1, e_k2;
  logic        [CW-1:0]  c_invc;
  logic                  c_vld, e_vld, w_vld;
  logic signed [EDW-1:0] e_ed;
  logic signed [EPW-1:0] e_ep;
  logic signed [T1W-1:0] w_t1;
  logic signed [T2W-1:0] w_t2;

  sls_capture #(.DW(DW), .KW(KW), .CW(CW)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_n_int), .en_i(smp_i),
    .vref_i(vref_i), .dvref_i(dvref_i), .vmeas_i(vmeas_i), .icap_i(icap_i),
    .k1_i(k1_i), .k2_i(k2_i), .invc_i(invc_i),
    .vref_o(c_vref), .dvref_o(c_dvref), .vmeas_o(c_vmeas), .icap_o(c_icap),
    .k1_o(c_k1), .k2_o(c_k2), .invc_o(c_invc), .vld_o(c_vld)
  );

  sls_error #(.DW(DW), .KW(KW), .CW(CW), .CF(CF)) u_err (
    .clk_i(clk_i), .rst_ni(rst_n_int), .vld_i(c_vld),
    .vref_i(c_vref), .dvref_i(c_dvref), .vmeas_i(c_vmeas), .icap_i(c_icap),
    .k1_i(c_k1), .k2_i(c_k2), .invc_i(c_invc),
    .ed_o(e_ed), .ep_o(e_ep), .k1_o(e_k1), .k2_o(e_k2), .vld_o(e_vld)
  );

  sls_weight #(.EDW(EDW), .EPW(EPW), .KW(KW)) u_wgt (
    .clk_i(clk_i), .rst_ni(rst_n_int), .vld_i(e_vld),
    .ed_i(e_ed), .ep_i(e_ep), .k1_i(e_k1), .k2_i(e_k2),
    .t1_o(w_t1), .t2_o(w_t2), .vld_o(w_vld)
  );

  sls_combine #(.T1W(T1W), .T2W(T2W), .A1(A1), .A2(A2), .SH(SH), .OW(OW)) u_cmb (
    .clk_i(clk_i), .rst_ni(rst_n_int), .vld_i(w_vld),
    .t1_i(w_t1), .t2_i(w_t2), .sw_o(sw_o), .vld_o(vld_o)
  );
endmodule

// File: rtl/sls_checker.sv
module sls_checker #(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 smp_i,
  input logic signed [DW-1:0] vref_i,
  input logic signed [DW-1:0] dvref_i,
  input logic signed [DW-1:0] vmeas_i,
  input logic signed [DW-1:0] icap_i,
  input logic signed [OW-1:0] sw_o,
  input logic                 vld_o
);
  logic [4:0] smp_sr, zero_sr;
  logic       zero_in;

  assign zero_in = smp_i && (vref_i == vmeas_i) && (dvref_i == '0) && (icap_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_sr  <= '0;
      zero_sr <= '0;
    end else begin
      smp_sr  <= {smp_sr[3:0], smp_i};
      zero_sr <= {zero_sr[3:0], zero_in};
    end
  end

  // R4: result strobe trails the sample strobe by a fixed count
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == smp_sr[4]);

  // R6: reset clears the outputs
  a_r6_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (sw_o == '0 && !vld_o));

  // R7: output word only moves with the strobe
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(sw_o));

  // R8: zero-error sample yields zero
  a_r8_zero_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && zero_sr[4]) |-> sw_o == '0);
endmodule

bind slide_surface_unit sls_checker #(.DW(DW), .OW(OW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i),
  .vref_i(vref_i), .dvref_i(dvref_i), .vmeas_i(vmeas_i), .icap_i(icap_i),
  .sw_o(sw_o), .vld_o(vld_o)
);

// File: tb/slide_surface_unit_test.sv
module slide_surface_unit_test;
  localparam int CF = 8, K1F = 12, K2F = 8, OF = 0;
  localparam int FA = (CF + K1F > K2F) ? CF + K1F : K2F;
  localparam int SH = FA - OF;
  localparam longint OMAX = 32767, OMIN = -32768;

  typedef struct packed {
    logic signed [15:0] vr;
    logic signed [15:0] dvr;
    logic signed [15:0] vm;
    logic signed [15:0] ic;
    logic        [15:0] k1;
    logic        [15:0] k2;
    logic        [15:0] inv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{16'sd1000,  16'sd50,  16'sd900,   16'sd40,  16'd4,    16'd640, 16'd256},
    '{-16'sd2000, -16'sd30, -16'sd1500, 16'sd100, 16'd4,    16'd640, 16'd256},
    '{16'sd0,     16'sd100, 16'sd0,     -16'sd50, 16'd4096, 16'd256, 16'd128},
    '{16'sd300,   16'sd0,   -16'sd300,  16'sd0,   16'd4096, 16'd256, 16'd256},
    '{16'sd10,    16'sd5,   16'sd20,    16'sd3,   16'd1000, 16'd100, 16'd1024},
    '{16'sd0,     16'sd0,   16'sd1,     16'sd0,   16'd0,    16'd1,   16'd0},
    '{16'sd0,     16'sd0,   -16'sd1,    16'sd0,   16'd0,    16'd1,   16'd0},
    '{16'sd5,     16'sd7,   16'sd9,     16'sd2,   16'd4096, 16'd0,   16'd512}
  };

  logic clk_i = 1'b0;
  logic rst_ni;
  logic smp_i;
  logic signed [15:0] vref_i, dvref_i, vmeas_i, icap_i;
  logic [15:0] k1_i, k2_i, invc_i;
  logic signed [15:0] sw_o;
  logic vld_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  slide_surface_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i),
    .vref_i(vref_i), .dvref_i(dvref_i), .vmeas_i(vmeas_i), .icap_i(icap_i),
    .k1_i(k1_i), .k2_i(k2_i), .invc_i(invc_i),
    .sw_o(sw_o), .vld_o(vld_o)
  );

  function automatic longint model(input vec_t v);
    longint ed, ep, t, r;
    ed = (longint'(v.dvr) <<< CF) - longint'(v.ic) * longint'(v.inv);
    ep = longint'(v.vr) - longint'(v.vm);
    t  = ((longint'(v.k1) * ed) <<< (FA - CF - K1F)) + ((longint'(v.k2) * ep) <<< (FA - K2F));
    r  = t >>> SH;
    if (r > OMAX) r = OMAX;
    if (r < OMIN) r = OMIN;
    return r;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    vref_i = v.vr; dvref_i = v.dvr; vmeas_i = v.vm; icap_i = v.ic;
    k1_i = v.k1; k2_i = v.k2; invc_i = v.inv;
    smp_i = 1'b1;
  endtask

  // called at a negedge; applies one sample and checks timing and value
  task automatic run_vec(input vec_t v, input string req);
    drive(v);
    @(negedge clk_i); smp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R4 early", longint'(vld_o), 0);
    @(negedge clk_i);
    chk("R4 strobe", longint'(vld_o), 1);
    chk(req, longint'(sw_o), model(v));
    @(negedge clk_i);
    chk("R4 one-cycle", longint'(vld_o), 0);
    chk("R7 hold", longint'(sw_o), model(v));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    vec_t a, b, c;
    longint ra;
    rst_ni = 1'b0; smp_i = 1'b0;
    vref_i = '0; dvref_i = '0; vmeas_i = '0; icap_i = '0;
    k1_i = '0; k2_i = '0; invc_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R6 reset sw", longint'(sw_o), 0);
    chk("R6 reset vld", longint'(vld_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R1: table walk
    for (int i = 0; i < NV; i++) run_vec(TBL[i], "R1 table");

    // R3: clamp at both rails
    a = '{16'sd32767, 16'sd0, -16'sd32768, 16'sd0, 16'd0, 16'hFFFF, 16'd0};
    run_vec(a, "R3 high");
    chk("R3 high value", longint'(sw_o), OMAX);
    a = '{-16'sd32768, 16'sd0, 16'sd32767, 16'sd0, 16'd0, 16'hFFFF, 16'd0};
    run_vec(a, "R3 low");
    chk("R3 low value", longint'(sw_o), OMIN);
    a = '{16'sd0, -16'sd32768, 16'sd0, 16'sd32767, 16'hFFFF, 16'd0, 16'hFFFF};
    run_vec(a, "R3 derivative low");

    // R8: zero error
    a = '{16'sd1234, 16'sd0, 16'sd1234, 16'sd0, 16'd4, 16'd640, 16'd256};
    run_vec(a, "R8 zero");
    chk("R8 zero value", longint'(sw_o), 0);

    // R2: history independence
    a = TBL[0];
    b = '{-16'sd7000, 16'sd900, 16'sd8000, -16'sd3000, 16'd4, 16'd640, 16'd256};
    run_vec(a, "R2 first");
    ra = longint'(sw_o);
    run_vec(b, "R2 other");
    run_vec(a, "R2 repeat");
    chk("R2 same result", longint'(sw_o), ra);

    // R5: config changed after capture
    a = TBL[4];
    drive(a);
    @(negedge clk_i); smp_i = 1'b0;
    k1_i = 16'd9999; k2_i = 16'd7; invc_i = 16'd3;
    repeat (4) @(negedge clk_i);
    chk("R5 strobe", longint'(vld_o), 1);
    chk("R5 in-flight gains", longint'(sw_o), model(a));
    @(negedge clk_i);

    // R4: back-to-back samples
    b = TBL[1]; c = TBL[2];
    drive(b);
    @(negedge clk_i); drive(c);
    @(negedge clk_i); smp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R4 b2b first vld", longint'(vld_o), 1);
    chk("R4 b2b first", longint'(sw_o), model(b));
    @(negedge clk_i);
    chk("R4 b2b second vld", longint'(vld_o), 1);
    chk("R4 b2b second", longint'(sw_o), model(c));
    @(negedge clk_i);
    chk("R4 b2b end", longint'(vld_o), 0);

    // R6: reset in flight
    drive(TBL[3]);
    @(negedge clk_i); smp_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R6 mid sw", longint'(sw_o), 0);
    chk("R6 mid vld", longint'(vld_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk("R6 discarded", longint'(vld_o), 0);
    end
    chk("R6 sw after", longint'(sw_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule